// File: doc/BRIEF.md
# Low-Power Entry and Wakeup Sequencer

This block decides when a small controller chip drops into its low-power state and brings it back out again. Software asks for power-down by writing a one into a single control bit. The sequencer first gates the CPU clock for one cycle. It then turns off the oscillator and the PLL and waits for a wakeup event. There are three possible wakeup sources: USB resume signalling, a dedicated wake pin, and a second wake pin that can instead be set up as plain general-purpose I/O. Each source behaves the same whether or not the chip is attached to USB.

When a source fires, the sequencer restarts the oscillator and holds the PLL off for a fixed oscillator-start interval. It then enables the PLL and waits for two things: a settle counter must run out, and the PLL lock input must be high. Only after both does it re-enable the CPU clock and pulse a wakeup interrupt for one cycle. The power-down bit clears itself at that point.

The analog oscillator and PLL are represented only by the lock input and the counters. The block moves no data, so all of its pins are plain control and status levels. It has no valid/ready interface and so no back-pressure rules.

Top module: `pwr_wake_seq`

## Requirements
- R1: After reset the block is in the run state: `osc_en_o`, `pll_en_o` and `cpu_clk_en_o` are 1, `wake_irq_o` is 0 and `pd_bit_o` is 0.
- R2: The power-down bit is written only while the CPU clock is running. A write with `pd_wdata_i`=1 sets `pd_bit_o` at the next edge, and a write with 0 leaves it at 0. A write issued while `cpu_clk_en_o` is 0 has no effect.
- R3: Once the bit is set, the sequencer spends exactly one cycle with the CPU clock gated while the oscillator and PLL are still on. It then turns both the oscillator and the PLL off and keeps them off until a wakeup event arrives.
- R4: A wakeup event is a rising edge, seen after a SYNC_STAGES-deep synchronizer, on `usb_resume_i`, on `wake_pin_i`, or on `wake2_pin_i`. Any one of these sources alone is enough to wake the block.
- R5: While `wake2_gpio_i` is 1, the second wake pin cannot wake the block.
- R6: A wakeup edge that arrives while the block is not asleep is discarded. A wake input that stays high therefore does not end a later power-down; only a fresh rising edge does.
- R7: After a wakeup event the oscillator runs with the PLL off and the CPU clock gated for exactly OSC_CYC cycles.
- R8: The PLL-settle phase has oscillator and PLL on and the CPU clock gated. With lock already high it lasts exactly SETTLE_CYC cycles. Otherwise it ends in the first cycle in which the counter has expired and `pll_lock_i` is high.
- R9: `wake_irq_o` is high for exactly one cycle, with the CPU clock enabled, right after the settle phase. The block is back in the run state in the following cycle.
- R10: `pd_bit_o` reads 0 from the cycle after the wakeup interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_wr_i | input | 1 | CPU write strobe for the power-down bit |
| pd_wdata_i | input | 1 | Value written to the power-down bit |
| pd_bit_o | output | 1 | Current power-down bit |
| usb_resume_i | input | 1 | USB resume indication, asynchronous |
| wake_pin_i | input | 1 | Dedicated wake pin, asynchronous |
| wake2_pin_i | input | 1 | Second wake pin, asynchronous |
| wake2_gpio_i | input | 1 | 1 = second pin is general-purpose I/O and cannot wake |
| pll_lock_i | input | 1 | PLL lock indication, synchronous to clk_i |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| cpu_clk_en_o | output | 1 | CPU clock-gate enable |
| wake_irq_o | output | 1 | One-cycle wakeup interrupt |

## Verification
The assertions make a few assumptions about the inputs:
- `pll_lock_i` is already synchronous to the reference clock.
- SYNC_STAGES is at least 2.
- Both cycle counts are at least 1.
- Software does not write 0 in the same cycle that a sleep begins.

The stimulus stays within these limits. It changes every input only on the falling edge, holds each wake pulse for several cycles so that it crosses the synchronizer, and raises lock only on a falling edge. It also issues power-down writes only while the clock is running, except for the one deliberate write made while asleep.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  // Sequencer states, in the order a sleep/wake cycle visits them.
  typedef enum logic [2:0] {
    PS_RUN        = 3'd0,
    PS_STOPPING   = 3'd1,
    PS_ASLEEP     = 3'd2,
    PS_OSC_START  = 3'd3,
    PS_PLL_SETTLE = 3'd4,
    PS_WAKE_IRQ   = 3'd5
  } pstate_e;

  // Wakeup source index positions.
  localparam int unsigned SRC_USB   = 0;
  localparam int unsigned SRC_WAKE  = 1;
  localparam int unsigned SRC_WAKE2 = 2;
  localparam int unsigned NUM_SRC   = 3;

endpackage

// File: rtl/pwr_wake_sync.sv
// Per-source synchronizer plus rising-edge detector, with an enable mask.
// SYNC_STAGES must be 2 or more.
module pwr_wake_sync #(
  parameter int unsigned NUM_SRC     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] edge_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] shreg;
    logic                   last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shreg  <= '0;
        last_q <= 1'b0;
      end else begin
        shreg  <= {shreg[SYNC_STAGES-2:0], src_i[g]};
        last_q <= shreg[SYNC_STAGES-1];
      end
    end

    assign edge_o[g] = shreg[SYNC_STAGES-1] & ~last_q & en_i[g];

    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o[g] |=> !edge_o[g]); // R6
  end

endmodule

// File: rtl/pwr_settle_timer.sv
// Loadable down-counter used for both the oscillator-start and the PLL-settle wait.
module pwr_settle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o); // R8

endmodule

// File: rtl/pwr_seq_fsm.sv
// Power state machine, power-down bit and clock/enable decode.
module pwr_seq_fsm
  import pwr_wake_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned OSC_CYC    = 16,
  parameter int unsigned SETTLE_CYC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_wr_i,
  input  logic             pd_wdata_i,
  input  logic             wake_any_i,
  input  logic             pll_lock_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             pd_bit_o,
  output logic             osc_en_o,
  output logic             pll_en_o,
  output logic             cpu_clk_en_o,
  output logic             wake_irq_o
);

  localparam logic [CNT_W-1:0] OSC_LOAD    = CNT_W'(OSC_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);

  pstate_e state_q, state_d;
  logic    pd_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = OSC_LOAD;
    unique case (state_q)
      PS_RUN:       if (pd_q) state_d = PS_STOPPING;
      PS_STOPPING:  state_d = PS_ASLEEP;
      PS_ASLEEP: begin
        if (wake_any_i) begin
          state_d    = PS_OSC_START;
          tmr_load_o = 1'b1;
          tmr_val_o  = OSC_LOAD;
        end
      end
      PS_OSC_START: begin
        if (tmr_done_i) begin
          state_d    = PS_PLL_SETTLE;
          tmr_load_o = 1'b1;
          tmr_val_o  = SETTLE_LOAD;
        end
      end
      PS_PLL_SETTLE: if (tmr_done_i && pll_lock_i) state_d = PS_WAKE_IRQ;
      PS_WAKE_IRQ:  state_d = PS_RUN;
      default:      state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  // Software writes land only while the CPU is clocked; the bit clears on wakeup.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q <= 1'b0;
    end else if (state_q == PS_WAKE_IRQ) begin
      pd_q <= 1'b0;
    end else if (state_q == PS_RUN && pd_wr_i) begin
      pd_q <= pd_wdata_i;
    end
  end

  always_comb begin
    osc_en_o     = 1'b1;
    pll_en_o     = 1'b1;
    cpu_clk_en_o = 1'b0;
    wake_irq_o   = 1'b0;
    unique case (state_q)
      PS_RUN:        cpu_clk_en_o = 1'b1;
      PS_STOPPING:   ;
      PS_ASLEEP: begin
        osc_en_o = 1'b0;
        pll_en_o = 1'b0;
      end
      PS_OSC_START:  pll_en_o = 1'b0;
      PS_PLL_SETTLE: ;
      PS_WAKE_IRQ: begin
        cpu_clk_en_o = 1'b1;
        wake_irq_o   = 1'b1;
      end
      default:       cpu_clk_en_o = 1'b1;
    endcase
  end

  assign pd_bit_o = pd_q;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> (!wake_irq_o && cpu_clk_en_o)); // R9
  AST_IRQ_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_irq_o) |-> ($past(pll_lock_i) && $past(pll_en_o) && !$past(cpu_clk_en_o))); // R8
  AST_PD_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> !pd_bit_o); // R10
  AST_OSC_BEFORE_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_en_o) |-> $past(osc_en_o)); // R7
  AST_STAY_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !wake_any_i) |=> !osc_en_o); // R4
  AST_GATE_BEFORE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> (!$past(cpu_clk_en_o) && $past(pd_bit_o))); // R3
  AST_NO_CLK_WITHOUT_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_o |-> !cpu_clk_en_o); // R7

endmodule

// File: rtl/pwr_wake_seq.sv
// Top: power-down entry and wakeup sequencing.
module pwr_wake_seq
  import pwr_wake_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OSC_CYC     = 64,
  parameter int unsigned SETTLE_CYC  = 2400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_wr_i,
  input  logic pd_wdata_i,
  output logic pd_bit_o,
  input  logic usb_resume_i,
  input  logic wake_pin_i,
  input  logic wake2_pin_i,
  input  logic wake2_gpio_i,
  input  logic pll_lock_i,
  output logic osc_en_o,
  output logic pll_en_o,
  output logic cpu_clk_en_o,
  output logic wake_irq_o
);

  localparam int unsigned MAX_CYC = (OSC_CYC > SETTLE_CYC) ? OSC_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [NUM_SRC-1:0] src_raw, src_en, src_edge;
  logic               wake_any;
  logic               tmr_load, tmr_done;
  logic [CNT_W-1:0]   tmr_val;

  always_comb begin
    src_raw            = '0;
    src_raw[SRC_USB]   = usb_resume_i;
    src_raw[SRC_WAKE]  = wake_pin_i;
    src_raw[SRC_WAKE2] = wake2_pin_i;
    src_en             = '1;
    src_en[SRC_WAKE2]  = ~wake2_gpio_i;
  end

  pwr_wake_sync #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_raw),
    .en_i  (src_en),
    .edge_o(src_edge)
  );

  assign wake_any = |src_edge;

  pwr_settle_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .done_o    (tmr_done)
  );

  pwr_seq_fsm #(
    .CNT_W     (CNT_W),
    .OSC_CYC   (OSC_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pd_wr_i     (pd_wr_i),
    .pd_wdata_i  (pd_wdata_i),
    .wake_any_i  (wake_any),
    .pll_lock_i  (pll_lock_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .pd_bit_o    (pd_bit_o),
    .osc_en_o    (osc_en_o),
    .pll_en_o    (pll_en_o),
    .cpu_clk_en_o(cpu_clk_en_o),
    .wake_irq_o  (wake_irq_o)
  );

  AST_GPIO_PIN_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake2_gpio_i |-> !src_edge[SRC_WAKE2]); // R5

endmodule

// File: tb/sim_pwr_wake_seq.sv
`timescale 1ns/1ps
module sim_pwr_wake_seq;

  localparam int unsigned OSC_CYC    = 5;
  localparam int unsigned SETTLE_CYC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_wr = 1'b0, pd_wdata = 1'b0;
  logic usb_res = 1'b0, wk = 1'b0, wk2 = 1'b0, wk2_gpio = 1'b0, lock = 1'b1;
  logic pd_bit, osc_en, pll_en, clk_en, irq;

  always #4 clk = ~clk;

  pwr_wake_seq #(
    .SYNC_STAGES(2),
    .OSC_CYC    (OSC_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pd_wr_i     (pd_wr),
    .pd_wdata_i  (pd_wdata),
    .pd_bit_o    (pd_bit),
    .usb_resume_i(usb_res),
    .wake_pin_i  (wk),
    .wake2_pin_i (wk2),
    .wake2_gpio_i(wk2_gpio),
    .pll_lock_i  (lock),
    .osc_en_o    (osc_en),
    .pll_en_o    (pll_en),
    .cpu_clk_en_o(clk_en),
    .wake_irq_o  (irq)
  );

  int checks = 0;
  int fails  = 0;
  logic [19:0] exp_q[$];
  string       tag_q[$];
  logic        mon_on = 1'b0;
  logic [3:0]  prev_v;
  int          run_len;

  localparam logic [3:0] V_RUN = 4'hE, V_GATE = 4'hC, V_OFF = 4'h0,
                         V_OSC = 4'h8, V_IRQ = 4'hF;

  wire [3:0] vec = {osc_en, pll_en, clk_en, irq};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] v, input int len, input string tag);
    exp_q.push_back({v, 16'(len)});
    tag_q.push_back(tag);
  endtask

  // Queue the phases of one complete sleep/wake cycle.
  task automatic push_cycle(input int settle_len);
    push(V_RUN, 0, "R2 run before sleep");
    push(V_GATE, 1, "R3 clock gated one cycle");
    push(V_OFF, 0, "R3 oscillator and PLL off");
    push(V_OSC, OSC_CYC, "R7 oscillator start");
    push(V_GATE, settle_len, "R8 PLL settle");
    push(V_IRQ, 1, "R9 interrupt pulse");
  endtask

  task automatic write_pd(input logic val);
    @(negedge clk); pd_wr = 1'b1; pd_wdata = val;
    @(negedge clk); pd_wr = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    repeat (3) @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!irq && n < 1000) begin @(negedge clk); n++; end
    check(irq == 1'b1, "R9 interrupt arrives", irq, 1);
    @(negedge clk);
    check(pd_bit == 1'b0, "R10 bit cleared after interrupt", pd_bit, 0);
    check(vec == V_RUN, "R9 back to run", vec, V_RUN);
  endtask

  // Monitor: pops one expected phase each time the output vector changes.
  always @(negedge clk) begin
    if (!mon_on) begin
      prev_v  = vec;
      run_len = 1;
    end else if (vec != prev_v) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected phase actual=%0h expected=none", prev_v);
      end else begin
        logic [19:0] it;
        string t;
        it = exp_q.pop_front();
        t  = tag_q.pop_front();
        check(prev_v == it[19:16], t, prev_v, it[19:16]);
        if (it[15:0] != 0) check(run_len == int'(it[15:0]), t, run_len, it[15:0]);
      end
      prev_v  = vec;
      run_len = 1;
    end else begin
      run_len++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(vec == V_RUN, "R1 reset enables", vec, V_RUN);
    check(pd_bit == 1'b0, "R1 reset bit", pd_bit, 0);
    check(irq == 1'b0, "R1 reset interrupt", irq, 0);
    mon_on = 1'b1;

    // Wake through the dedicated pin, lock already high.
    push_cycle(SETTLE_CYC);
    write_pd(1'b1);
    check(pd_bit == 1'b1, "R2 write sets bit", pd_bit, 1);
    repeat (10) @(negedge clk);
    check(osc_en == 1'b0 && pll_en == 1'b0, "R3 asleep", vec, V_OFF);
    pulse(wk);
    wait_irq();

    // Wake through USB resume, lock arrives late (R4, R8).
    lock = 1'b0;
    push_cycle(21);
    write_pd(1'b1);
    repeat (10) @(negedge clk);
    pulse(usb_res);
    while (!(osc_en && !pll_en)) @(negedge clk);
    while (!pll_en) @(negedge clk);
    repeat (20) @(negedge clk);
    lock = 1'b1;
    wait_irq();

    // Second pin as GPIO cannot wake (R5); as wake pin it can (R4).
    wk2_gpio = 1'b1;
    push_cycle(SETTLE_CYC);
    write_pd(1'b1);
    repeat (5) @(negedge clk);
    pulse(wk2);
    repeat (30) @(negedge clk);
    check(osc_en == 1'b0, "R5 gpio-mode pin ignored", osc_en, 0);
    wk2_gpio = 1'b0;
    pulse(wk2);
    wait_irq();

    // Held level: edge while running is discarded, no later wake (R6).
    @(negedge clk); wk = 1'b1;
    repeat (10) @(negedge clk);
    check(vec == V_RUN, "R6 edge while running ignored", vec, V_RUN);
    push_cycle(SETTLE_CYC);
    write_pd(1'b1);
    repeat (30) @(negedge clk);
    check(osc_en == 1'b0, "R6 held level does not wake", osc_en, 0);
    wk = 1'b0;
    repeat (5) @(negedge clk);
    check(osc_en == 1'b0, "R6 falling edge does not wake", osc_en, 0);
    write_pd(1'b0);
    check(pd_bit == 1'b1, "R2 write while gated ignored", pd_bit, 1);
    pulse(usb_res);
    wait_irq();

    // Writing 0 while running keeps the bit clear and stays awake (R2).
    write_pd(1'b0);
    repeat (10) @(negedge clk);
    check(pd_bit == 1'b0, "R2 write of zero", pd_bit, 0);
    check(vec == V_RUN, "R2 no sleep after zero write", vec, V_RUN);
    check(exp_q.size() == 0, "R9 all phases seen", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule